// File: doc/BRIEF.md
# Global 64-bit Compare Timer

This block holds a free-running 64-bit up-counter and a single 64-bit compare unit. When the counter and the compare value become equal, the block raises a level interrupt. A set run bit starts the counter. The compare unit can fire once (one-shot), or it can fire periodically: in that mode it adds a programmed step to the compare value on every match. Software reaches all state through a flat 32-bit register port. Writes are accepted in one cycle and reads are combinational.

The block models a slow internal clock domain. Writes to the counter halves, the compare halves, the step register and the control register do not act at once. Each takes effect a fixed `SYNC_LAT` cycles after it is accepted. In that same cycle a sticky write-status flag rises for the register that was written. Software polls the flag and clears it by writing 1 to it. The counter halves are read live, with no snapshot. A consistent 64-bit value therefore needs a high, low, high read sequence, repeated if the two high reads differ.

Top module: `gct_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq_o` is low.
- R2: While the run bit (bit 8 of the control word at 0x240) is set, the counter advances by one each cycle. While the bit is clear, the counter holds its value.
- R3: The counter low half (0x100) and high half (0x104) are writable. Both read live, and the low half carries into the high half. A value read back is the current count, with no latch.
- R4: A write to 0x100, 0x104, 0x200 (compare low), 0x204 (compare high), 0x208 (step) or 0x240 (control) takes effect exactly `SYNC_LAT` cycles after the write is accepted. Until then a read returns the old value.
- R5: Each write in R4 sets a sticky flag when the write takes effect. At 0x24C the flags are bit 0 for compare low, bit 1 for compare high, bit 2 for step and bit 16 for control. At 0x110 they are bit 0 for counter low and bit 1 for counter high. Writing 1 to a flag bit clears it, and writing 0 to it leaves it unchanged.
- R6: A match occurs when the full 64-bit counter equals the compare value while the counter runs and compare-enable (bit 0 of 0x240) is set. A match sets status bit 0 at 0x244 on that edge.
- R7: With auto-step (bit 1 of 0x240) set, each match adds the step value at 0x208 to the compare value, so matches repeat every step cycles.
- R8: With auto-step clear, the compare value is unchanged by a match, so only one match occurs before the counter wraps.
- R9: Writing 1 to bit 0 of 0x244 clears the status flag immediately. A match in the same cycle wins.
- R10: `irq_o` is the status flag ANDed with interrupt-enable bit 0 at 0x248. The enable register is written immediately.
- R11: Reads of unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a write to a latency-tracked register is not followed by another write to the same register before the first one takes effect. A rewrite in that window restarts the delay, and the properties do not model that case. The assertions also assume the bus holds no unknown values after reset. The directed stimulus drives one write per two cycles and waits for each flag, or for `SYNC_LAT` cycles, before it rewrites the same register. It holds `bus_we` low outside write tasks and keeps the address driven at all times.

// File: rtl/gct_pkg.sv
package gct_pkg;
   // Register byte offsets (software-visible layout)
   localparam int OFF_CNT_L = 'h100;
   localparam int OFF_CNT_H = 'h104;
   localparam int OFF_CWS   = 'h110;
   localparam int OFF_CMP_L = 'h200;
   localparam int OFF_CMP_H = 'h204;
   localparam int OFF_STEP  = 'h208;
   localparam int OFF_CTL   = 'h240;
   localparam int OFF_IST   = 'h244;
   localparam int OFF_IEN   = 'h248;
   localparam int OFF_GWS   = 'h24C;

   // Delayed-write slots
   localparam int NSLOT  = 6;
   localparam int S_CLO  = 0;
   localparam int S_CHI  = 1;
   localparam int S_CMPL = 2;
   localparam int S_CMPH = 3;
   localparam int S_STEP = 4;
   localparam int S_CTL  = 5;

   // Control word bit positions
   localparam int CTL_RUN  = 8;
   localparam int CTL_AUTO = 1;
   localparam int CTL_EN   = 0;

   function automatic int slot_off(input int s);
      case (s)
         S_CLO:   return OFF_CNT_L;
         S_CHI:   return OFF_CNT_H;
         S_CMPL:  return OFF_CMP_L;
         S_CMPH:  return OFF_CMP_H;
         S_STEP:  return OFF_STEP;
         default: return OFF_CTL;
      endcase
   endfunction
endpackage

// File: rtl/gct_wsync.sv
module gct_wsync #(
   parameter int DW  = 32,
   parameter int LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic          apply,
   output logic [DW-1:0] dout
);
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    data_q <= '0;
      else if (load) data_q <= din;
   end
   assign dout = data_q;

   generate
      if (LAT < 1) begin : g_bad
         $error("gct_wsync: LAT must be at least 1");
      end else if (LAT == 1) begin : g_direct
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= load;
         end
         assign apply = pend_q;
      end else begin : g_count
         localparam int CTW = $clog2(LAT + 1);
         logic [CTW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              left_q <= '0;
            else if (load)           left_q <= CTW'(LAT);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign apply = (left_q == CTW'(1));
      end
   endgenerate
endmodule

// File: rtl/gct_core.sv
module gct_core
   import gct_pkg::*;
#(
   parameter int DW = 32,
   localparam int CW = 2 * DW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSLOT-1:0]     apply,
   input  logic [NSLOT*DW-1:0]  adata,
   output logic [CW-1:0]        cnt_q,
   output logic [CW-1:0]        cmp_q,
   output logic [DW-1:0]        step_q,
   output logic                 run,
   output logic                 cmp_en,
   output logic                 auto_step,
   output logic                 match
);
   logic [DW-1:0] d [NSLOT];
   logic [2:0]    ctl_q;
   logic [CW-1:0] cnt_n, cmp_n;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_unpack
         assign d[s] = adata[s*DW +: DW];
      end
   endgenerate

   assign run       = ctl_q[2];
   assign auto_step = ctl_q[1];
   assign cmp_en    = ctl_q[0];
   assign match     = run && cmp_en && (cnt_q == cmp_q);

   always_comb begin
      cnt_n = run ? cnt_q + 1'b1 : cnt_q;
      if (apply[S_CLO] || apply[S_CHI])
         cnt_n = {apply[S_CHI] ? d[S_CHI] : cnt_q[CW-1:DW],
                  apply[S_CLO] ? d[S_CLO] : cnt_q[DW-1:0]};
      cmp_n = cmp_q;
      if (match && auto_step) cmp_n = cmp_q + CW'(step_q);
      if (apply[S_CMPL]) cmp_n[DW-1:0]  = d[S_CMPL];
      if (apply[S_CMPH]) cmp_n[CW-1:DW] = d[S_CMPH];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cmp_q  <= '0;
         step_q <= '0;
         ctl_q  <= '0;
      end else begin
         cnt_q <= cnt_n;
         cmp_q <= cmp_n;
         if (apply[S_STEP]) step_q <= d[S_STEP];
         if (apply[S_CTL])
            ctl_q <= {d[S_CTL][CTL_RUN], d[S_CTL][CTL_AUTO], d[S_CTL][CTL_EN]};
      end
   end
endmodule

// File: rtl/gct_timer.sv
module gct_timer
   import gct_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 32,
   parameter int SYNC_LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_o
);
   localparam int CW = 2 * DW;

   generate
      if (DW != 32) begin : g_dw_chk
         $error("gct_timer: register layout assumes DW == 32");
      end
      if (AW < 10) begin : g_aw_chk
         $error("gct_timer: AW too small for register offsets");
      end
   endgenerate

   logic [NSLOT-1:0]    load, apply;
   logic [NSLOT*DW-1:0] adata;
   logic [CW-1:0]       cnt_q, cmp_q;
   logic [DW-1:0]       step_q;
   logic                run, cmp_en, auto_step, match;
   logic                istat_q, ien_q;
   logic [3:0]          gws_q;   // {ctl, step, cmp_h, cmp_l}
   logic [1:0]          cws_q;   // {cnt_h, cnt_l}

   function automatic logic hit(input int off);
      return bus_addr == AW'(off);
   endfunction

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign load[s] = bus_we && hit(slot_off(s));
         gct_wsync #(.DW(DW), .LAT(SYNC_LAT)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[s]),
            .din   (bus_wdata),
            .apply (apply[s]),
            .dout  (adata[s*DW +: DW])
         );
      end
   endgenerate

   gct_core #(.DW(DW)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .adata     (adata),
      .cnt_q     (cnt_q),
      .cmp_q     (cmp_q),
      .step_q    (step_q),
      .run       (run),
      .cmp_en    (cmp_en),
      .auto_step (auto_step),
      .match     (match)
   );

   logic [3:0] gws_set, gws_clr;
   logic [1:0] cws_set, cws_clr;
   assign gws_set = {apply[S_CTL], apply[S_STEP], apply[S_CMPH], apply[S_CMPL]};
   assign cws_set = {apply[S_CHI], apply[S_CLO]};
   assign gws_clr = (bus_we && hit(OFF_GWS)) ?
                    {bus_wdata[16], bus_wdata[2:0]} : 4'b0;
   assign cws_clr = (bus_we && hit(OFF_CWS)) ? bus_wdata[1:0] : 2'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         istat_q <= 1'b0;
         ien_q   <= 1'b0;
         gws_q   <= '0;
         cws_q   <= '0;
      end else begin
         istat_q <= match | (istat_q & ~(bus_we && hit(OFF_IST) && bus_wdata[0]));
         if (bus_we && hit(OFF_IEN)) ien_q <= bus_wdata[0];
         gws_q <= gws_set | (gws_q & ~gws_clr);
         cws_q <= cws_set | (cws_q & ~cws_clr);
      end
   end

   assign irq_o = istat_q & ien_q;

   always_comb begin
      bus_rdata = '0;
      if      (hit(OFF_CNT_L)) bus_rdata = cnt_q[DW-1:0];
      else if (hit(OFF_CNT_H)) bus_rdata = cnt_q[CW-1:DW];
      else if (hit(OFF_CWS))   bus_rdata[1:0] = cws_q;
      else if (hit(OFF_CMP_L)) bus_rdata = cmp_q[DW-1:0];
      else if (hit(OFF_CMP_H)) bus_rdata = cmp_q[CW-1:DW];
      else if (hit(OFF_STEP))  bus_rdata = step_q;
      else if (hit(OFF_CTL)) begin
         bus_rdata[CTL_RUN]  = run;
         bus_rdata[CTL_AUTO] = auto_step;
         bus_rdata[CTL_EN]   = cmp_en;
      end
      else if (hit(OFF_IST))   bus_rdata[0] = istat_q;
      else if (hit(OFF_IEN))   bus_rdata[0] = ien_q;
      else if (hit(OFF_GWS)) begin
         bus_rdata[2:0] = gws_q[2:0];
         bus_rdata[16]  = gws_q[3];
      end
   end
endmodule

// File: rtl/gct_timer_chk.sv
module gct_timer_chk
   import gct_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 32,
   localparam int CW = 2 * DW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_wdata,
   input logic             irq_o,
   input logic [CW-1:0]    cnt_q,
   input logic [CW-1:0]    cmp_q,
   input logic [DW-1:0]    step_q,
   input logic             run,
   input logic             cmp_en,
   input logic             auto_step,
   input logic             istat_q,
   input logic             ien_q,
   input logic [3:0]       gws_q,
   input logic [NSLOT-1:0] apply
);
   logic cnt_wr, cmp_wr, gws0_clr, ist_clr, hit_now;
   assign cnt_wr   = apply[S_CLO] | apply[S_CHI];
   assign cmp_wr   = apply[S_CMPL] | apply[S_CMPH];
   assign gws0_clr = bus_we && bus_addr == AW'(OFF_GWS) && bus_wdata[0];
   assign ist_clr  = bus_we && bus_addr == AW'(OFF_IST) && bus_wdata[0];
   assign hit_now  = run && cmp_en && (cnt_q == cmp_q);

   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt_q));
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (gws_q[0] && !gws0_clr) |=> gws_q[0]);
   a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit_now |=> istat_q);
   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_now && auto_step && !cmp_wr) |=> cmp_q == $past(cmp_q) + CW'($past(step_q)));
   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_now && !auto_step && !cmp_wr) |=> $stable(cmp_q));
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ist_clr && !hit_now) |=> !istat_q);
   a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ien_q);
endmodule

bind gct_timer gct_timer_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .cnt_q     (cnt_q),
   .cmp_q     (cmp_q),
   .step_q    (step_q),
   .run       (run),
   .cmp_en    (cmp_en),
   .auto_step (auto_step),
   .istat_q   (istat_q),
   .ien_q     (ien_q),
   .gws_q     (gws_q),
   .apply     (apply)
);

// File: tb/gct_timer_bench.sv
module gct_timer_bench;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;   // 200 MHz

   gct_timer #(.AW(12), .DW(32), .SYNC_LAT(LAT)) u_gct_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_now(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_now(a, d);
   endtask

   task automatic settle();
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic wait_irq(output bit ok);
      ok = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (irq_o) begin ok = 1; break; end
      end
   endtask

   // Stop, zero counter, program compare/step, clear flags
   task automatic setup(input logic [31:0] cmp, input logic [31:0] stp);
      wr('h240, 32'h0);
      wr('h100, 32'h0);
      wr('h104, 32'h0);
      wr('h200, cmp);
      wr('h204, 32'h0);
      wr('h208, stp);
      settle();
      wr('h244, 32'h1);
      wr('h24C, 32'h0001_0007);
      wr('h110, 32'h3);
   endtask

   task automatic t_reset();
      int offs[10] = '{'h100, 'h104, 'h110, 'h200, 'h204, 'h208, 'h240, 'h244, 'h248, 'h24C};
      for (int i = 0; i < 10; i++) begin
         rd(12'(offs[i]), rv);
         check($sformatf("R1 reg 0x%03h", offs[i]), rv, 32'h0);
      end
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      repeat (5) @(negedge clk);
      rd('h100, rv);
      check("R2 stopped counter holds", rv, 32'h0);
   endtask

   task automatic t_latency();
      logic [31:0] ws;
      wr('h200, 32'h0000_ABCD);             // write edge E0, now after E0
      rd_now('h200, rv);
      check("R4 compare old before latency", rv, 32'h0);
      rd_now('h24C, ws);
      check("R5 flag low before latency", ws, 32'h0);
      repeat (LAT - 1) @(negedge clk);      // after E(LAT-1)
      rd_now('h200, rv);
      check("R4 compare old one cycle early", rv, 32'h0);
      @(negedge clk);                       // after E(LAT)
      rd_now('h200, rv);
      check("R4 compare applied at latency", rv, 32'h0000_ABCD);
      rd_now('h24C, ws);
      check("R5 compare-low flag set", ws, 32'h1);
      wr('h24C, 32'h2);
      rd('h24C, ws);
      check("R5 clearing other bit leaves flag", ws, 32'h1);
      wr('h24C, 32'h1);
      rd('h24C, ws);
      check("R5 write-1 clears flag", ws, 32'h0);
      wr('h104, 32'h0000_0007);
      settle();
      rd('h110, ws);
      check("R5 counter-high flag at 0x110 bit1", ws, 32'h2);
      rd('h104, rv);
      check("R3 counter high written", rv, 32'h7);
      wr('h110, 32'h3);
      rd('h110, ws);
      check("R5 counter flags cleared", ws, 32'h0);
   endtask

   task automatic t_oneshot();
      bit ok;
      setup(32'd100, 32'd0);
      wr('h248, 32'h1);
      wr('h240, 32'h0000_0101);             // run + compare enable
      settle();
      rd_now('h24C, rv);
      check("R5 control flag bit16", rv, 32'h0001_0000);
      wait_irq(ok);
      check("R6 one-shot match seen", {31'b0, ok}, 32'h1);
      rd_now('h100, rv);
      check("R6 counter one past compare at irq", rv, 32'd101);
      rd_now('h200, rv);
      check("R8 compare unchanged by match", rv, 32'd100);
      wr('h244, 32'h1);
      rd_now('h244, rv);
      check("R9 status cleared", rv, 32'h0);
      repeat (300) @(negedge clk);
      check("R8 no second one-shot irq", {31'b0, irq_o}, 32'h0);
      rd_now('h100, rv);
      check("R2 counter kept running", {31'b0, rv > 32'd300}, 32'h1);
   endtask

   task automatic t_periodic();
      bit ok;
      setup(32'd100, 32'd50);
      wr('h248, 32'h1);
      wr('h240, 32'h0000_0103);             // run + enable + auto-step
      wait_irq(ok);
      rd_now('h100, rv);
      check("R7 first periodic match", rv, 32'd101);
      rd_now('h200, rv);
      check("R7 compare stepped to 150", rv, 32'd150);
      wr('h244, 32'h1);
      check("R9 irq low after clear", {31'b0, irq_o}, 32'h0);
      wait_irq(ok);
      rd_now('h100, rv);
      check("R7 second periodic match", rv, 32'd151);
      rd_now('h200, rv);
      check("R7 compare stepped to 200", rv, 32'd200);
      wr('h244, 32'h1);
   endtask

   task automatic t_mask();
      setup(32'd5, 32'd0);
      wr('h248, 32'h0);
      wr('h240, 32'h0000_0101);
      repeat (20) @(negedge clk);
      check("R10 irq masked while disabled", {31'b0, irq_o}, 32'h0);
      rd_now('h244, rv);
      check("R6 status set while masked", rv, 32'h1);
      wr('h248, 32'h1);
      check("R10 irq follows enable", {31'b0, irq_o}, 32'h1);
      wr('h244, 32'h1);
   endtask

   task automatic t_torn();
      logic [31:0] h1, lo, h2;
      int retries = 0;
      bit found = 0;
      wr('h240, 32'h0);
      wr('h100, 32'hFFFF_FFF0);
      wr('h104, 32'h0000_0005);
      settle();
      wr('h240, 32'h0000_0100);
      for (int i = 0; i < 100; i++) begin
         rd('h100, rv);
         if (rv == 32'hFFFF_FFFD) begin found = 1; break; end
      end
      check("R3 counter reached pre-rollover", {31'b0, found}, 32'h1);
      rd('h104, h2);
      do begin
         h1 = h2;
         rd('h100, lo);
         rd('h104, h2);
         if (h1 != h2) retries++;
      end while (h1 != h2 && retries < 4);
      check("R3 torn read detected once", retries, 32'd1);
      check("R3 consistent high after carry", h1, 32'h6);
      check("R3 consistent low after carry", lo, 32'h1);
   endtask

   task automatic t_unmapped();
      wr('h0FC, 32'hDEAD_BEEF);
      rd('h0FC, rv);
      check("R11 unmapped read zero", rv, 32'h0);
      rd('h24C, rv);
      check("R11 unmapped write sets no flag", rv, 32'h0);
      rd('h110, rv);
      check("R11 unmapped write leaves counter flags", rv, 32'h0);
   endtask

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_oneshot();
      t_periodic();
      t_mask();
      t_torn();
      wr('h24C, 32'h0001_0007);
      wr('h110, 32'h3);
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule